// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

The block gathers up to 96 level-sensitive interrupt lines, organised as three banks of 32, and presents two request outputs to a processor. One output is the normal request and the other is the fast request. Each line carries its own priority and a route bit that sends it to one output or the other. A line competes for its output while it is pending and not masked. Software can also raise a line through a per-bank software word. When several lines compete, the one with the smallest priority value wins. The winning line number is latched as a source code, and the output stays raised until software grants a new agreement through the control register.

Software reaches the block through a 4 KB window of 32-bit word registers on a simple request/response port. The port takes one access per cycle and has no back-pressure: `req_valid` with `req_write` high is a write that takes effect at that clock edge. `req_valid` with `req_write` low is a read. Its data returns on `rsp_data` with `rsp_valid` exactly one cycle later. The response cannot be stalled, so the consumer must take it in that cycle. An address whose two low bits are not zero is treated as unmapped.

Top module: `intc_top`

## Requirements
- R1: After reset, outputs are low and every mask bit is 1. Offset 0x00 reads 0x21 and offset 0x14 reads 1. Priorities, routes, source codes, the idle register, the control register and the software words all read 0.
- R2: A read returns `rsp_valid` high exactly one cycle later, with the data of the state at the request edge. A write produces no response.
- R3: The raw input view of bank b is at 0x80+0x20*b, with line n in bit n. A rising input sets its raw bit and its pending bit. When any input of a bank falls, that bank's pending word becomes its current inputs ORed with its software word.
- R4: 0x98+0x20*b reads pending AND NOT mask AND NOT route. 0x9C+0x20*b reads pending AND NOT mask AND route.
- R5: 0x84+0x20*b writes the mask. 0x88+0x20*b clears the mask bits that are written as 1, and 0x8C+0x20*b sets them. Both aliases read 0.
- R6: A write to 0x90+0x20*b ORs the value into the software word and into pending. A write to 0x94+0x20*b clears the written bits from the software word and then sets pending to the software word AND the current inputs. 0x90 reads the software word and 0x94 reads 0.
- R7: The line register of global line g = 32*b+n is at 0x100+0x80*b+4*n. Bit 0 is the route (1 = fast output) and bits 7:2 are the priority. It reads back the same way, with bit 1 reading 0.
- R8: While an output is armed, not globally masked and has a competing line, the output rises one cycle later. At that point it latches the code of the line with the lowest priority value, ties going to the highest global line number. The code reads at 0x40 for the normal output and 0x44 for the fast output, and it holds until the next agreement.
- R9: At 0x48, writing bit 0 as 1 drops the normal output in the next cycle and re-arms it. Bit 1 does the same for the fast output. A re-armed output rises again if lines still compete.
- R10: Bit 2 at 0x48 is a global mask and reads back in bit 2. While it is set, both outputs read low and no new agreement is made.
- R11: Bit 0 at 0x10 is stored and reads back. Writing bit 1 at 0x10 returns the whole controller to its reset state.
- R12: The two low bits at 0x50 are stored and read back. A write to 0x4C has no effect, and 0x4C reads 0.
- R13: A bank access to a bank number at or above the bank count reads 0, and a write to it is ignored. Unmapped offsets read 0. Writes to read-only registers (raw input, source codes, pending views) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 96 | Level-sensitive interrupt lines, global line g in bit g |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset in the register window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_data | output | 32 | Read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The arbitration is driven with distinct priorities, with equal priorities, and with a single source on each route. These cases separate the lowest-value rule, the highest-index tie break and the route split. The software word is set and cleared both while the matching input is low and while an unrelated input is high. This exposes the AND-with-inputs quirk of the clear and the OR-back on a falling edge. The global mask, the soft reset and accesses to an absent bank show whether those controls reach the outputs or stay inert. A behavioural model with its own integer arrays tracks every cycle, so a late or early output edge is caught as well as a wrong value.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int DATA_W = 32;
  localparam int LINE_W = $clog2(DATA_W);

  // word indices (byte offset >> 2) inside the global block
  localparam logic [4:0] W_REV    = 5'h00;
  localparam logic [4:0] W_SYSCFG = 5'h04;
  localparam logic [4:0] W_STAT   = 5'h05;
  localparam logic [4:0] W_CODE_N = 5'h10;
  localparam logic [4:0] W_CODE_F = 5'h11;
  localparam logic [4:0] W_CTRL   = 5'h12;
  localparam logic [4:0] W_PROT   = 5'h13;
  localparam logic [4:0] W_IDLE   = 5'h14;

  typedef enum logic [2:0] {
    BR_RAW   = 3'd0,
    BR_MASK  = 3'd1,
    BR_MCLR  = 3'd2,
    BR_MSET  = 3'd3,
    BR_SSET  = 3'd4,
    BR_SCLR  = 3'd5,
    BR_PNORM = 3'd6,
    BR_PFAST = 3'd7
  } bank_reg_e;

  typedef struct packed {
    logic              mask_wr;
    logic              mask_clr;
    logic              mask_set;
    logic              sw_set;
    logic              sw_clr;
    logic              line_wr;
    logic [LINE_W-1:0] line;
  } bank_cmd_t;
endpackage

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
#(
  parameter int LINES  = 32,
  parameter int PRIO_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    soft_rst,
  input  logic [LINES-1:0]        lvl_in,
  input  bank_cmd_t               cmd,
  input  logic [LINES-1:0]        wval,
  output logic [LINES-1:0]        raw_q,
  output logic [LINES-1:0]        mask_q,
  output logic [LINES-1:0]        swi_q,
  output logic [LINES-1:0]        view_norm,
  output logic [LINES-1:0]        view_fast,
  output logic [LINES*PRIO_W-1:0] prio_q,
  output logic [LINES-1:0]        route_q
);
  logic [LINES-1:0] pend_q, pend_n, swi_n, mask_n;

  always_comb begin
    if (|(raw_q & ~lvl_in)) pend_n = lvl_in | swi_q;
    else                    pend_n = pend_q | (lvl_in & ~raw_q);
    swi_n = swi_q;
    if (cmd.sw_set) begin
      swi_n  = swi_q | wval;
      pend_n = pend_n | wval;
    end
    if (cmd.sw_clr) begin
      swi_n  = swi_q & ~wval;
      pend_n = swi_n & lvl_in;
    end
    mask_n = mask_q;
    if (cmd.mask_wr)  mask_n = wval;
    if (cmd.mask_clr) mask_n = mask_q & ~wval;
    if (cmd.mask_set) mask_n = mask_q | wval;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0; pend_q <= '0; swi_q <= '0; mask_q <= '1;
      prio_q <= '0; route_q <= '0;
    end else if (soft_rst) begin
      raw_q <= '0; pend_q <= '0; swi_q <= '0; mask_q <= '1;
      prio_q <= '0; route_q <= '0;
    end else begin
      raw_q  <= lvl_in;
      pend_q <= pend_n;
      swi_q  <= swi_n;
      mask_q <= mask_n;
      if (cmd.line_wr) begin
        prio_q[cmd.line*PRIO_W +: PRIO_W] <= wval[PRIO_W+1:2];
        route_q[cmd.line]                 <= wval[0];
      end
    end
  end

  assign view_norm = pend_q & ~mask_q & ~route_q;
  assign view_fast = pend_q & ~mask_q & route_q;
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int N      = 96,
  parameter int PRIO_W = 6,
  parameter int IDX_W  = $clog2(N)
) (
  input  logic [N-1:0]        act,
  input  logic [N*PRIO_W-1:0] prio,
  output logic                any,
  output logic [IDX_W-1:0]    idx
);
  logic [PRIO_W-1:0] best;

  // later lines win ties, so the scan runs upward with a non-strict compare
  always_comb begin
    any  = 1'b0;
    idx  = '0;
    best = '1;
    for (int i = 0; i < N; i++) begin
      if (act[i] && (prio[i*PRIO_W +: PRIO_W] <= best)) begin
        any  = 1'b1;
        best = prio[i*PRIO_W +: PRIO_W];
        idx  = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int          NUM_BANKS = 3,
  parameter int          LINES     = 32,
  parameter int          PRIO_W    = 6,
  parameter logic [7:0]  REVISION  = 8'h21
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_BANKS*LINES-1:0]   irq_in,
  input  logic                         req_valid,
  input  logic                         req_write,
  input  logic [11:0]                  req_addr,
  input  logic [LINES-1:0]             req_wdata,
  output logic                         rsp_valid,
  output logic [LINES-1:0]             rsp_data,
  output logic                         irq_o,
  output logic                         fiq_o
);
  localparam int NL     = NUM_BANKS * LINES;
  localparam int CODE_W = $clog2(NL);
  localparam int NPATH  = 2;

  logic wr_en, rd_en, addr_ok, in_glob, in_bank, in_line, bank_ok;
  logic [4:0] gword, region, lbank;
  logic [1:0] bsel;
  bank_reg_e  breg;
  logic       soft_rst;

  assign wr_en   = req_valid & req_write;
  assign rd_en   = req_valid & ~req_write;
  assign addr_ok = (req_addr[1:0] == 2'b00);
  assign region  = req_addr[11:7];
  assign gword   = req_addr[6:2];
  assign bsel    = req_addr[6:5];
  assign breg    = bank_reg_e'(req_addr[4:2]);
  assign lbank   = region - 5'd2;
  assign in_glob = addr_ok && (region == 5'd0);
  assign bank_ok = int'(bsel) < NUM_BANKS;
  assign in_bank = addr_ok && (region == 5'd1) && bank_ok;
  assign in_line = addr_ok && (region >= 5'd2) && (region < 5'(2 + NUM_BANKS));
  assign soft_rst = wr_en && in_glob && (gword == W_SYSCFG) && req_wdata[1];

  logic [NL-1:0]        raw_all, mask_all, swi_all, route_all;
  logic [NPATH*NL-1:0]  act_all;
  logic [NL*PRIO_W-1:0] prio_all;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bank_cmd_t cmd;
    logic hit_b, hit_l;
    assign hit_b        = wr_en && in_bank && (int'(bsel) == b);
    assign hit_l        = wr_en && in_line && (int'(lbank) == b);
    assign cmd.mask_wr  = hit_b && (breg == BR_MASK);
    assign cmd.mask_clr = hit_b && (breg == BR_MCLR);
    assign cmd.mask_set = hit_b && (breg == BR_MSET);
    assign cmd.sw_set   = hit_b && (breg == BR_SSET);
    assign cmd.sw_clr   = hit_b && (breg == BR_SCLR);
    assign cmd.line_wr  = hit_l;
    assign cmd.line     = req_addr[6:2];

    intc_bank #(.LINES(LINES), .PRIO_W(PRIO_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .lvl_in   (irq_in[b*LINES +: LINES]),
      .cmd      (cmd),
      .wval     (req_wdata),
      .raw_q    (raw_all[b*LINES +: LINES]),
      .mask_q   (mask_all[b*LINES +: LINES]),
      .swi_q    (swi_all[b*LINES +: LINES]),
      .view_norm(act_all[b*LINES +: LINES]),
      .view_fast(act_all[NL + b*LINES +: LINES]),
      .prio_q   (prio_all[b*LINES*PRIO_W +: LINES*PRIO_W]),
      .route_q  (route_all[b*LINES +: LINES])
    );
  end

  // path 0 = normal output, path 1 = fast output
  logic [NPATH-1:0]  any_p, flag_q, armed_q;
  logic [CODE_W-1:0] win_p  [NPATH];
  logic [CODE_W-1:0] code_q [NPATH];
  logic              gmask_q, autoidle_q;
  logic [1:0]        idle_q;

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    intc_arbiter #(.N(NL), .PRIO_W(PRIO_W), .IDX_W(CODE_W)) u_arb (
      .act (act_all[p*NL +: NL]),
      .prio(prio_all),
      .any (any_p[p]),
      .idx (win_p[p])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[p] <= 1'b0; armed_q[p] <= 1'b1; code_q[p] <= '0;
      end else if (soft_rst) begin
        flag_q[p] <= 1'b0; armed_q[p] <= 1'b1; code_q[p] <= '0;
      end else if (wr_en && in_glob && (gword == W_CTRL) && req_wdata[p]) begin
        flag_q[p]  <= 1'b0;
        armed_q[p] <= 1'b1;
      end else if (armed_q[p] && any_p[p] && !gmask_q) begin
        flag_q[p]  <= 1'b1;
        armed_q[p] <= 1'b0;
        code_q[p]  <= win_p[p];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gmask_q <= 1'b0; autoidle_q <= 1'b0; idle_q <= '0;
    end else if (soft_rst) begin
      gmask_q <= 1'b0; autoidle_q <= 1'b0; idle_q <= '0;
    end else if (wr_en && in_glob) begin
      if (gword == W_CTRL)   gmask_q    <= req_wdata[2];
      if (gword == W_SYSCFG) autoidle_q <= req_wdata[0];
      if (gword == W_IDLE)   idle_q     <= req_wdata[1:0];
    end
  end

  logic [LINES-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (in_glob) begin
      case (gword)
        W_REV:    rd_mux = LINES'(REVISION);
        W_SYSCFG: rd_mux = LINES'(autoidle_q);
        W_STAT:   rd_mux = LINES'(1);
        W_CODE_N: rd_mux = LINES'(code_q[0]);
        W_CODE_F: rd_mux = LINES'(code_q[1]);
        W_CTRL:   rd_mux = LINES'({gmask_q, 2'b00});
        W_IDLE:   rd_mux = LINES'(idle_q);
        default:  rd_mux = '0;
      endcase
    end else if (in_bank) begin
      case (breg)
        BR_RAW:   rd_mux = raw_all[bsel*LINES +: LINES];
        BR_MASK:  rd_mux = mask_all[bsel*LINES +: LINES];
        BR_SSET:  rd_mux = swi_all[bsel*LINES +: LINES];
        BR_PNORM: rd_mux = act_all[bsel*LINES +: LINES];
        BR_PFAST: rd_mux = act_all[NL + bsel*LINES +: LINES];
        default:  rd_mux = '0;
      endcase
    end else if (in_line) begin
      rd_mux = LINES'({prio_all[(lbank*LINES + gword)*PRIO_W +: PRIO_W],
                       1'b0, route_all[lbank*LINES + gword]});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rsp_data <= rd_mux;
    end
  end

  assign irq_o = flag_q[0] & ~gmask_q;
  assign fiq_o = flag_q[1] & ~gmask_q;
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int NUM_BANKS = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [11:0] req_addr,
  input logic [31:0] req_wdata,
  input logic        rsp_valid,
  input logic [31:0] rsp_data,
  input logic        irq_o,
  input logic        fiq_o
);
  logic wr_ctrl, wr_cfg;
  assign wr_ctrl = req_valid && req_write && (req_addr == 12'h048);
  assign wr_cfg  = req_valid && req_write && (req_addr == 12'h010);

  assert_read_answers_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  assert_write_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> !rsp_valid);

  assert_status_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == 12'h014) |=> (rsp_data == 32'd1));

  assert_norm_ack_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && req_wdata[0]) |=> !irq_o);

  assert_fast_ack_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && req_wdata[1]) |=> !fiq_o);

  assert_gmask_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && req_wdata[2]) |=> (!irq_o && !fiq_o));

  assert_soft_reset_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cfg && req_wdata[1]) |=> (!irq_o && !fiq_o));

  assert_absent_bank_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr[11:7] == 5'd1 && req_addr[1:0] == 2'b00 &&
     int'(req_addr[6:5]) >= NUM_BANKS) |=> (rsp_data == 32'd0));
endmodule

bind intc_top intc_checker #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_addr (req_addr),
  .req_wdata(req_wdata),
  .rsp_valid(rsp_valid),
  .rsp_data (rsp_data),
  .irq_o    (irq_o),
  .fiq_o    (fiq_o)
);

// File: tb/tb_intc_top.sv
`timescale 1ns/1ps
module tb_intc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] irq_in = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, irq_o, fiq_o;
  logic [31:0] rsp_data;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  intc_top dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  // ---------------- behavioural reference ----------------
  logic [31:0] m_raw[3], m_pend[3], m_mask[3], m_swi[3], m_route[3];
  int          m_prio[96];
  bit          m_gmask, m_auto, m_rvalid;
  logic [1:0]  m_idle;
  int          m_code[2];
  bit          m_flag[2], m_armed[2];
  logic [31:0] m_rdata;

  task automatic m_reset();
    for (int b = 0; b < 3; b++) begin
      m_raw[b] = 0; m_pend[b] = 0; m_mask[b] = '1; m_swi[b] = 0; m_route[b] = 0;
    end
    for (int g = 0; g < 96; g++) m_prio[g] = 0;
    m_gmask = 0; m_auto = 0; m_idle = 0;
    for (int p = 0; p < 2; p++) begin m_code[p] = 0; m_flag[p] = 0; m_armed[p] = 1; end
  endtask

  function automatic logic [31:0] m_read(logic [11:0] a);
    int reg_i, b;
    if (a[1:0] != 0) return 0;
    reg_i = int'(a[6:2]);
    if (a[11:7] == 0) begin
      case (reg_i)
        0: return 32'h21;
        4: return 32'(m_auto);
        5: return 1;
        16: return 32'(m_code[0]);
        17: return 32'(m_code[1]);
        18: return m_gmask ? 32'd4 : 32'd0;
        20: return 32'(m_idle);
        default: return 0;
      endcase
    end
    if (a[11:7] == 1) begin
      b = int'(a[6:5]);
      if (b >= 3) return 0;
      case (int'(a[4:2]))
        0: return m_raw[b];
        1: return m_mask[b];
        4: return m_swi[b];
        6: return m_pend[b] & ~m_mask[b] & ~m_route[b];
        7: return m_pend[b] & ~m_mask[b] & m_route[b];
        default: return 0;
      endcase
    end
    b = int'(a[11:7]) - 2;
    if (b < 3) return 32'((m_prio[b*32 + reg_i] * 4) + int'(m_route[b][reg_i]));
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reset();
      m_rvalid = 0; m_rdata = 0;
    end else begin
      bit v, w;
      logic [11:0] a;
      logic [31:0] d;
      logic [95:0] lv;
      int win[2];
      bit has[2];
      v = req_valid; w = req_write; a = req_addr; d = req_wdata; lv = irq_in;
      m_rvalid = v && !w;
      if (m_rvalid) m_rdata = m_read(a);
      for (int p = 0; p < 2; p++) begin
        int best;
        best = 1000; has[p] = 0; win[p] = 0;
        for (int g = 0; g < 96; g++) begin
          int bb, ll;
          bb = g / 32; ll = g % 32;
          if (m_pend[bb][ll] && !m_mask[bb][ll] && (int'(m_route[bb][ll]) == p) &&
              m_prio[g] <= best) begin
            best = m_prio[g]; win[p] = g; has[p] = 1;
          end
        end
      end
      if (v && w && a == 12'h010 && d[1]) m_reset();
      else begin
        for (int b = 0; b < 3; b++) begin
          logic [31:0] nin;
          nin = lv[b*32 +: 32];
          if ((m_raw[b] & ~nin) != 0) m_pend[b] = nin | m_swi[b];
          else m_pend[b] = m_pend[b] | (nin & ~m_raw[b]);
          m_raw[b] = nin;
          if (v && w && a[11:7] == 1 && a[1:0] == 0 && int'(a[6:5]) == b) begin
            case (int'(a[4:2]))
              1: m_mask[b] = d;
              2: m_mask[b] = m_mask[b] & ~d;
              3: m_mask[b] = m_mask[b] | d;
              4: begin m_swi[b] = m_swi[b] | d; m_pend[b] = m_pend[b] | d; end
              5: begin m_swi[b] = m_swi[b] & ~d; m_pend[b] = m_swi[b] & nin; end
              default: ;
            endcase
          end
          if (v && w && a[1:0] == 0 && int'(a[11:7]) == b + 2) begin
            m_prio[b*32 + int'(a[6:2])] = int'(d[7:2]);
            m_route[b][int'(a[6:2])] = d[0];
          end
        end
        for (int p = 0; p < 2; p++) begin
          if (v && w && a == 12'h048 && d[p]) begin m_flag[p] = 0; m_armed[p] = 1; end
          else if (m_armed[p] && has[p] && !m_gmask) begin
            m_flag[p] = 1; m_armed[p] = 0; m_code[p] = win[p];
          end
        end
        if (v && w && a == 12'h048) m_gmask = d[2];
        if (v && w && a == 12'h010) m_auto = d[0];
        if (v && w && a == 12'h050) m_idle = d[1:0];
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (irq_o !== (m_flag[0] && !m_gmask)) begin
        fails++; $display("FAIL R8 irq_o actual %0b expected %0b", irq_o, m_flag[0] && !m_gmask);
      end
      checks++;
      if (fiq_o !== (m_flag[1] && !m_gmask)) begin
        fails++; $display("FAIL R8 fiq_o actual %0b expected %0b", fiq_o, m_flag[1] && !m_gmask);
      end
      checks++;
      if (rsp_valid !== m_rvalid) begin
        fails++; $display("FAIL R2 rsp_valid actual %0b expected %0b", rsp_valid, m_rvalid);
      end else if (rsp_valid && rsp_data !== m_rdata) begin
        fails++; $display("FAIL R2 rsp_data actual %h expected %h", rsp_data, m_rdata);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    checks++;
    if (rsp_data !== exp) begin
      fails++; $display("FAIL %s read %h actual %h expected %h", tag, a, rsp_data, exp);
    end
  endtask

  task automatic out_chk(input bit ei, input bit ef, input string tag);
    checks++;
    if (irq_o !== ei || fiq_o !== ef) begin
      fails++; $display("FAIL %s outputs actual %0b%0b expected %0b%0b", tag, irq_o, fiq_o, ei, ef);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; fails++; checks++;
      $display("FAIL watchdog actual running expected finished");
      summary();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    idle(1);
    // R1 reset state
    out_chk(0, 0, "R1");
    rd_chk(12'h000, 32'h21, "R1");
    rd_chk(12'h014, 32'h1, "R1");
    rd_chk(12'h084, 32'hFFFF_FFFF, "R1");
    rd_chk(12'h040, 0, "R1");
    rd_chk(12'h050, 0, "R1");
    // R7 line configuration
    wr(12'h114, 32'h0C);
    rd_chk(12'h114, 32'h0C, "R7");
    wr(12'h1A0, 32'h05);
    rd_chk(12'h1A0, 32'h05, "R7");
    // R3 rising input, R5 mask clear, R4 pending view, R8 code
    @(negedge clk); irq_in[5] = 1;
    idle(2);
    rd_chk(12'h080, 32'h20, "R3");
    rd_chk(12'h098, 0, "R4");
    wr(12'h088, 32'h20);
    rd_chk(12'h084, 32'hFFFF_FFDF, "R5");
    rd_chk(12'h098, 32'h20, "R4");
    idle(1);
    out_chk(1, 0, "R8");
    rd_chk(12'h040, 32'd5, "R8");
    // fast route
    @(negedge clk); irq_in[40] = 1;
    wr(12'h0A4, 32'hFFFF_FEFF);
    idle(2);
    rd_chk(12'h0BC, 32'h100, "R4");
    rd_chk(12'h0B8, 0, "R4");
    rd_chk(12'h044, 32'd40, "R8");
    out_chk(1, 1, "R8");
    // priority and tie order
    @(negedge clk); irq_in[70] = 1;
    wr(12'h0C8, 32'h40);
    rd_chk(12'h040, 32'd5, "R8");
    wr(12'h048, 32'h1);
    idle(2);
    out_chk(1, 1, "R9");
    rd_chk(12'h040, 32'd70, "R8");
    wr(12'h114, 32'h0);
    wr(12'h048, 32'h1);
    idle(2);
    rd_chk(12'h040, 32'd70, "R8");
    wr(12'h218, 32'h08);
    wr(12'h048, 32'h1);
    idle(2);
    rd_chk(12'h040, 32'd5, "R8");
    // R9 no competitors after ack
    @(negedge clk); irq_in[5] = 0; irq_in[40] = 0; irq_in[70] = 0;
    idle(2);
    wr(12'h048, 32'h3);
    idle(3);
    out_chk(0, 0, "R9");
    // R6 software word
    wr(12'h090, 32'h1);
    rd_chk(12'h090, 32'h1, "R6");
    rd_chk(12'h080, 32'h0, "R6");
    wr(12'h088, 32'h1);
    idle(2);
    out_chk(1, 0, "R6");
    rd_chk(12'h040, 32'd0, "R6");
    wr(12'h094, 32'h1);
    rd_chk(12'h098, 32'h0, "R6");
    rd_chk(12'h090, 32'h0, "R6");
    wr(12'h048, 32'h1);
    idle(2);
    out_chk(0, 0, "R9");
    @(negedge clk); irq_in[3] = 1;
    idle(2);
    wr(12'h090, 32'h10);
    wr(12'h094, 32'h0);
    wr(12'h088, 32'h18);
    rd_chk(12'h098, 32'h0, "R6");
    rd_chk(12'h090, 32'h10, "R6");
    // R3 falling input restores the software word
    @(negedge clk); irq_in[3] = 0;
    idle(2);
    rd_chk(12'h098, 32'h10, "R3");
    idle(1);
    out_chk(1, 0, "R8");
    rd_chk(12'h040, 32'd4, "R8");
    // R10 global mask
    wr(12'h048, 32'h4);
    out_chk(0, 0, "R10");
    rd_chk(12'h048, 32'h4, "R10");
    wr(12'h048, 32'h0);
    out_chk(1, 0, "R10");
    // R11 sysconfig and soft reset
    wr(12'h010, 32'h1);
    rd_chk(12'h010, 32'h1, "R11");
    wr(12'h114, 32'h14);
    wr(12'h010, 32'h2);
    out_chk(0, 0, "R11");
    rd_chk(12'h084, 32'hFFFF_FFFF, "R11");
    rd_chk(12'h010, 32'h0, "R11");
    rd_chk(12'h090, 32'h0, "R11");
    rd_chk(12'h114, 32'h0, "R11");
    // R12 idle and protection
    wr(12'h050, 32'h7);
    rd_chk(12'h050, 32'h3, "R12");
    wr(12'h04C, 32'h1);
    rd_chk(12'h04C, 32'h0, "R12");
    // R13 absent bank, unmapped, read-only
    rd_chk(12'h0E0, 32'h0, "R13");
    wr(12'h0E4, 32'h0);
    rd_chk(12'h084, 32'hFFFF_FFFF, "R13");
    rd_chk(12'h0A4, 32'hFFFF_FFFF, "R13");
    rd_chk(12'h0C4, 32'hFFFF_FFFF, "R13");
    @(negedge clk); irq_in[2] = 1;
    idle(2);
    wr(12'h080, 32'h0);
    rd_chk(12'h080, 32'h4, "R13");
    wr(12'h040, 32'h55);
    rd_chk(12'h040, 32'h0, "R13");
    rd_chk(12'h020, 32'h0, "R13");
    rd_chk(12'h300, 32'h0, "R13");
    rd_chk(12'h116, 32'h0, "R13");
    idle(3);
    done = 1;
    summary();
  end
endmodule